// File: doc/BRIEF.md
# Function-Indexed Three-Level Address Translation Walker

The walker turns a 48-bit guest local-memory address, issued on behalf of one virtual function, into a 48-bit host local-memory address. It reads the answer out of a translation table held in memory. That table has three tiers. The top tier has one 64-bit entry per function number. The middle tier has 64-bit entries selected by the high guest address bits. The bottom tier has 32-bit entries selected by the middle guest address bits, and each of these names a 2 MB host page.

A request carries a function number and a guest address, and is accepted over a valid/ready handshake. The walker takes the top-tier base from a root pointer input at the moment it accepts the request. It then reads one entry per tier over a single read port. Each read sends an address with a one-cycle strobe and waits for the data to come back with a valid flag. The walk ends in a held response that carries either the host address or a fault and the tier that caused it. Only one walk runs at a time.

All table pointers are 32-bit numbers of 64 KB blocks. A tier's base address is therefore the pointer shifted left by 16.

Top module: `xw_walker`

## Requirements
- R1: Out of reset, `req_ready_o` is 1, and `rsp_valid_o` and `mem_rd_o` are both 0.
- R2: A request for function 0 produces a fault with `rsp_level_o` = 0 and issues no memory read.
- R3: The first read of a walk is at root_ptr×65536 + fn×8. Top-tier entries are valid when bit 0 is set, and they carry the next pointer in bits 35:4.
- R4: The second read is at ptr×65536 + gaddr[47:35]×8, where ptr is the top-tier entry's pointer. Middle-tier entries use the same layout as top-tier entries.
- R5: The third read is at ptr×65536 + gaddr[34:21]×4, where ptr is the middle-tier entry's pointer. The 32-bit leaf entry is read data bits 63:32 when that address has bit 2 set, and bits 31:0 otherwise.
- R6: A leaf entry with bit 0 set gives `rsp_fault_o` = 0, `rsp_level_o` = 2 and `rsp_haddr_o` = {leaf bits 31:5, gaddr[20:0]}.
- R7: An entry with bit 0 clear ends the walk with `rsp_fault_o` = 1, `rsp_haddr_o` = 0 and `rsp_level_o` = the tier (0 top, 1 middle, 2 leaf). No further read is issued.
- R8: While a response is pending, `req_ready_o` is 0 and new requests are not taken. The response holds its values until a cycle with `rsp_ready_i` high.
- R9: The root pointer is sampled only when a request is accepted. Changing it during a walk does not affect that walk, but the next walk uses the new value.
- R10: Only one read is outstanding at a time. `mem_rd_o` is a single-cycle strobe, and it is never repeated before data returns.
- R11: Reserved entry bits (63:36 and 3:1 of 64-bit entries, 4:1 of leaf entries) do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| root_ptr_i | input | 32 | Top-tier base in 64 KB units |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Walker idle and able to accept |
| req_fn_i | input | 6 | Function number |
| req_gaddr_i | input | 48 | Guest address |
| mem_rd_o | output | 1 | Read strobe |
| mem_addr_o | output | 48 | Byte address of the entry read |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 64 | Read data (aligned 8-byte word) |
| rsp_valid_o | output | 1 | Response pending |
| rsp_ready_i | input | 1 | Response consumed |
| rsp_fault_o | output | 1 | Translation fault |
| rsp_level_o | output | 2 | Tier that ended the walk |
| rsp_haddr_o | output | 48 | Host address (0 on fault) |

## Verification
The assertions assume two things about the memory side. First, the port returns exactly one data beat for each strobe, some cycles later. Second, `mem_rvalid_i` is never raised while no read is outstanding. The bench's memory model meets both conditions: it answers every strobe in the very next cycle and asserts valid at no other time. Requests are driven only between edges, and the response is consumed with single-cycle pulses. Unpopulated table locations read as zero, so they act as invalid entries.

// File: rtl/xw_pkg.sv
package xw_pkg;
  localparam int GAW     = 48;
  localparam int FN_W    = 6;
  localparam int MDW     = 64;
  localparam int PTR_W   = 32;
  localparam int TBL_SH  = 16;
  localparam int PAGE_SH = 21;
  localparam int MID_LO  = 35;
  localparam int MID_W   = GAW - MID_LO;
  localparam int LEAF_W  = MID_LO - PAGE_SH;
  localparam int PG_W    = GAW - PAGE_SH;
  localparam int LEAF_EW = 32;

  typedef enum logic [1:0] {
    LVL_TOP  = 2'd0,
    LVL_MID  = 2'd1,
    LVL_LEAF = 2'd2
  } lvl_e;

  function automatic logic [GAW-1:0] tbl_base(input logic [PTR_W-1:0] p);
    return GAW'(p) << TBL_SH;
  endfunction

  function automatic logic [GAW-1:0] entry_addr(input logic [PTR_W-1:0] p,
                                                input lvl_e lv,
                                                input logic [FN_W-1:0] fn,
                                                input logic [GAW-1:0] ga);
    logic [GAW-1:0] off;
    case (lv)
      LVL_TOP: off = GAW'(fn) << 3;
      LVL_MID: off = GAW'(ga[GAW-1:MID_LO]) << 3;
      default: off = GAW'(ga[MID_LO-1:PAGE_SH]) << 2;
    endcase
    return tbl_base(p) + off;
  endfunction

  function automatic logic [GAW-1:0] host_addr(input logic [PG_W-1:0] pg,
                                               input logic [GAW-1:0] ga);
    return {pg, ga[PAGE_SH-1:0]};
  endfunction
endpackage

// File: rtl/xw_addr_gen.sv
module xw_addr_gen
  import xw_pkg::*;
(
  input  logic [PTR_W-1:0] ptr_i,
  input  lvl_e             lvl_i,
  input  logic [FN_W-1:0]  fn_i,
  input  logic [GAW-1:0]   ga_i,
  output logic [GAW-1:0]   addr_o
);
  assign addr_o = entry_addr(ptr_i, lvl_i, fn_i, ga_i);
endmodule

// File: rtl/xw_entry_dec.sv
module xw_entry_dec
  import xw_pkg::*;
(
  input  logic [MDW-1:0]   data_i,
  input  lvl_e             lvl_i,
  input  logic             hi_half_i,
  output logic             ok_o,
  output logic [PTR_W-1:0] nxt_ptr_o,
  output logic [PG_W-1:0]  page_o
);
  logic [LEAF_EW-1:0] leaf_w;
  logic               unused_bits;

  assign leaf_w    = hi_half_i ? data_i[MDW-1:LEAF_EW] : data_i[LEAF_EW-1:0];
  assign ok_o      = (lvl_i == LVL_LEAF) ? leaf_w[0] : data_i[0];
  assign nxt_ptr_o = data_i[PTR_W+3:4];
  assign page_o    = leaf_w[LEAF_EW-1:LEAF_EW-PG_W];
  assign unused_bits = ^{data_i[MDW-1:PTR_W+4], data_i[3:1], leaf_w[4:1]};
endmodule

// File: rtl/xw_ctrl.sv
module xw_ctrl
  import xw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PTR_W-1:0] root_ptr_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [FN_W-1:0]  req_fn_i,
  input  logic [GAW-1:0]   req_gaddr_i,
  output logic             mem_rd_o,
  input  logic             mem_rvalid_i,
  input  logic             ent_ok_i,
  input  logic [PTR_W-1:0] nxt_ptr_i,
  input  logic [PG_W-1:0]  page_i,
  output lvl_e             lvl_o,
  output logic [PTR_W-1:0] ptr_o,
  output logic [FN_W-1:0]  fn_o,
  output logic [GAW-1:0]   ga_o,
  output logic             rsp_valid_o,
  input  logic             rsp_ready_i,
  output logic             rsp_fault_o,
  output logic [1:0]       rsp_level_o,
  output logic [GAW-1:0]   rsp_haddr_o
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_RESP} st_e;
  st_e st;

  logic accept, beat, bad_entry, last_tier;
  assign accept      = req_valid_i && req_ready_o;
  assign beat        = (st == S_WAIT) && mem_rvalid_i;
  assign bad_entry   = beat && !ent_ok_i;
  assign last_tier   = (lvl_o == LVL_LEAF);
  assign req_ready_o = (st == S_IDLE);
  assign mem_rd_o    = (st == S_ISSUE);
  assign rsp_valid_o = (st == S_RESP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      lvl_o       <= LVL_TOP;
      ptr_o       <= '0;
      fn_o        <= '0;
      ga_o        <= '0;
      rsp_fault_o <= 1'b0;
      rsp_level_o <= 2'd0;
      rsp_haddr_o <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          fn_o  <= req_fn_i;
          ga_o  <= req_gaddr_i;
          ptr_o <= root_ptr_i;
          lvl_o <= LVL_TOP;
          if (req_fn_i == '0) begin
            rsp_fault_o <= 1'b1;
            rsp_level_o <= LVL_TOP;
            rsp_haddr_o <= '0;
            st          <= S_RESP;
          end else begin
            st <= S_ISSUE;
          end
        end
        S_ISSUE: st <= S_WAIT;
        S_WAIT: if (beat) begin
          if (bad_entry) begin
            rsp_fault_o <= 1'b1;
            rsp_level_o <= lvl_o;
            rsp_haddr_o <= '0;
            st          <= S_RESP;
          end else if (last_tier) begin
            rsp_fault_o <= 1'b0;
            rsp_level_o <= LVL_LEAF;
            rsp_haddr_o <= host_addr(page_i, ga_o);
            st          <= S_RESP;
          end else begin
            ptr_o <= nxt_ptr_i;
            lvl_o <= (lvl_o == LVL_TOP) ? LVL_MID : LVL_LEAF;
            st    <= S_ISSUE;
          end
        end
        default: if (rsp_ready_i) st <= S_IDLE;
      endcase
    end
  end

  // R8: no new request while a response is pending
  a_r8_ready_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |-> !req_ready_o);
  // R8: response is held under back-pressure
  a_r8_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_haddr_o)
      && $stable(rsp_fault_o) && $stable(rsp_level_o));
  // R10: strobe is a single cycle
  a_r10_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |=> !mem_rd_o);
  // R2: function 0 faults straight away at the top tier
  a_r2_fn_zero: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_fn_i == '0 |=> rsp_valid_o && rsp_fault_o && rsp_level_o == 2'd0);
  // R7: no read while a response is pending
  a_r7_no_read_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |-> !mem_rd_o);
  // R6: page offset passes through on success
  a_r6_offset: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o && !rsp_fault_o |-> rsp_haddr_o[PAGE_SH-1:0] == ga_o[PAGE_SH-1:0]);
  // R7: fault responses carry no address
  a_r7_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o && rsp_fault_o |-> rsp_haddr_o == '0 && rsp_level_o != 2'd3);
endmodule

// File: rtl/xw_walker.sv
module xw_walker
  import xw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      root_ptr_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [5:0]       req_fn_i,
  input  logic [47:0]      req_gaddr_i,
  output logic             mem_rd_o,
  output logic [47:0]      mem_addr_o,
  input  logic             mem_rvalid_i,
  input  logic [63:0]      mem_rdata_i,
  output logic             rsp_valid_o,
  input  logic             rsp_ready_i,
  output logic             rsp_fault_o,
  output logic [1:0]       rsp_level_o,
  output logic [47:0]      rsp_haddr_o
);
  lvl_e             lvl;
  logic [PTR_W-1:0] ptr;
  logic [FN_W-1:0]  fn;
  logic [GAW-1:0]   ga;
  logic             ent_ok;
  logic [PTR_W-1:0] nxt_ptr;
  logic [PG_W-1:0]  page;

  xw_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .root_ptr_i(root_ptr_i),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_fn_i(req_fn_i), .req_gaddr_i(req_gaddr_i),
    .mem_rd_o(mem_rd_o), .mem_rvalid_i(mem_rvalid_i),
    .ent_ok_i(ent_ok), .nxt_ptr_i(nxt_ptr), .page_i(page),
    .lvl_o(lvl), .ptr_o(ptr), .fn_o(fn), .ga_o(ga),
    .rsp_valid_o(rsp_valid_o), .rsp_ready_i(rsp_ready_i),
    .rsp_fault_o(rsp_fault_o), .rsp_level_o(rsp_level_o),
    .rsp_haddr_o(rsp_haddr_o)
  );

  xw_addr_gen u_addr (
    .ptr_i(ptr), .lvl_i(lvl), .fn_i(fn), .ga_i(ga), .addr_o(mem_addr_o)
  );

  xw_entry_dec u_dec (
    .data_i(mem_rdata_i), .lvl_i(lvl), .hi_half_i(mem_addr_o[2]),
    .ok_o(ent_ok), .nxt_ptr_o(nxt_ptr), .page_o(page)
  );

  // R10: the entry address is steady while its data is awaited
  a_r10_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |=> $stable(mem_addr_o));
endmodule

// File: tb/tb_xw_walker.sv
module tb_xw_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] root_ptr_i = 32'h10;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [5:0]  req_fn_i = '0;
  logic [47:0] req_gaddr_i = '0;
  logic        mem_rd_o;
  logic [47:0] mem_addr_o;
  logic        mem_rvalid_i = 1'b0;
  logic [63:0] mem_rdata_i = '0;
  logic        rsp_valid_o;
  logic        rsp_ready_i = 1'b0;
  logic        rsp_fault_o;
  logic [1:0]  rsp_level_o;
  logic [47:0] rsp_haddr_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  xw_walker dut (.*);

  logic [63:0] mem [logic [44:0]];
  logic [47:0] rd_log [$];

  always @(posedge clk) begin
    mem_rvalid_i <= 1'b0;
    if (mem_rd_o) begin
      mem_rvalid_i <= 1'b1;
      mem_rdata_i  <= mem.exists(mem_addr_o[47:3]) ? mem[mem_addr_o[47:3]] : 64'h0;
      rd_log.push_back(mem_addr_o);
    end
  end

  logic        r_fault;
  logic [1:0]  r_lvl;
  logic [47:0] r_haddr;

  function automatic void chk(input bit ok, input string tag, input logic [63:0] act,
                              input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endfunction

  function automatic logic [47:0] blk(input logic [31:0] p);
    return {p, 16'h0000};
  endfunction

  function automatic void put64(input logic [47:0] a, input logic [63:0] d);
    mem[a[47:3]] = d;
  endfunction

  function automatic void put32(input logic [47:0] a, input logic [31:0] d);
    logic [63:0] w;
    w = mem.exists(a[47:3]) ? mem[a[47:3]] : 64'h0;
    if (a[2]) w[63:32] = d; else w[31:0] = d;
    mem[a[47:3]] = w;
  endfunction

  function automatic logic [47:0] ga_of(input logic [12:0] hi, input logic [13:0] mid,
                                        input logic [20:0] off);
    return {hi, mid, off};
  endfunction

  task automatic send_req(input logic [5:0] fn, input logic [47:0] ga);
    rd_log.delete();
    @(negedge clk);
    req_valid_i = 1'b1; req_fn_i = fn; req_gaddr_i = ga;
    @(posedge clk); #1;
    req_valid_i = 1'b0;
  endtask

  task automatic wait_rsp();
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (rsp_valid_o) break;
    end
    r_fault = rsp_fault_o; r_lvl = rsp_level_o; r_haddr = rsp_haddr_o;
  endtask

  task automatic ack_rsp();
    @(negedge clk); rsp_ready_i = 1'b1;
    @(posedge clk); #1; rsp_ready_i = 1'b0;
  endtask

  task automatic walk(input logic [5:0] fn, input logic [47:0] ga);
    send_req(fn, ga); wait_rsp();
    chk(rsp_valid_o, "R8 response appears", 64'(rsp_valid_o), 64'd1);
    ack_rsp();
  endtask

  task automatic t_reset();
    #1;
    chk(req_ready_o == 1'b1, "R1 ready in reset", 64'(req_ready_o), 64'd1);
    chk(rsp_valid_o == 1'b0, "R1 rsp_valid in reset", 64'(rsp_valid_o), 64'd0);
    chk(mem_rd_o == 1'b0, "R1 no read in reset", 64'(mem_rd_o), 64'd0);
  endtask

  task automatic t_fn_zero();
    walk(6'd0, ga_of(13'h0A5, 14'h1235, 21'h1));
    chk(r_fault && r_lvl == 2'd0, "R2 fault at tier 0", {r_fault, r_lvl}, 64'h4);
    chk(rd_log.size() == 0, "R2 no reads", 64'(rd_log.size()), 64'd0);
  endtask

  task automatic t_good(input logic [5:0] fn, input logic [47:0] ga,
                        input logic [31:0] root, input logic [31:0] p2,
                        input logic [31:0] p3, input logic [26:0] pg);
    logic [47:0] exp_h;
    walk(fn, ga);
    exp_h = {pg, ga[20:0]};
    chk(rd_log.size() == 3, "R10 three reads", 64'(rd_log.size()), 64'd3);
    if (rd_log.size() == 3) begin
      chk(rd_log[0] == blk(root) + 48'(fn) * 8, "R3 top address", 64'(rd_log[0]),
          64'(blk(root) + 48'(fn) * 8));
      chk(rd_log[1] == blk(p2) + 48'(ga[47:35]) * 8, "R4 mid address", 64'(rd_log[1]),
          64'(blk(p2) + 48'(ga[47:35]) * 8));
      chk(rd_log[2] == blk(p3) + 48'(ga[34:21]) * 4, "R5 leaf address", 64'(rd_log[2]),
          64'(blk(p3) + 48'(ga[34:21]) * 4));
    end
    chk(!r_fault && r_lvl == 2'd2, "R6 success status", {r_fault, r_lvl}, 64'h2);
    chk(r_haddr == exp_h, "R6 R5 R11 host address", 64'(r_haddr), 64'(exp_h));
  endtask

  task automatic t_fault(input logic [5:0] fn, input logic [47:0] ga,
                         input logic [1:0] lv);
    walk(fn, ga);
    chk(r_fault && r_lvl == lv && r_haddr == 48'h0, "R7 fault tier", {r_fault, r_lvl},
        {61'h0, 1'b1, lv});
    chk(rd_log.size() == int'(lv) + 1, "R7 reads stop", 64'(rd_log.size()), 64'(lv + 1));
  endtask

  task automatic t_backpressure();
    logic [47:0] ga;
    ga = ga_of(13'h0A5, 14'h1234, 21'h0_0042);
    send_req(6'd5, ga); wait_rsp();
    rd_log.delete();
    @(negedge clk); req_valid_i = 1'b1; req_fn_i = 6'd9; req_gaddr_i = '0;
    repeat (5) begin
      @(negedge clk);
      chk(rsp_valid_o && !req_ready_o, "R8 held while pending", {rsp_valid_o, req_ready_o},
          64'h2);
      chk(rsp_haddr_o == r_haddr && rsp_fault_o == r_fault, "R8 values stable",
          64'(rsp_haddr_o), 64'(r_haddr));
    end
    req_valid_i = 1'b0;
    chk(rd_log.size() == 0, "R8 request not taken", 64'(rd_log.size()), 64'd0);
    ack_rsp();
    #1;
    chk(req_ready_o && !rsp_valid_o, "R8 idle after consume", {req_ready_o, rsp_valid_o},
        64'h2);
  endtask

  task automatic t_root_change();
    logic [47:0] ga;
    ga = ga_of(13'h0A5, 14'h1235, 21'h1_ABCD);
    send_req(6'd5, ga);
    root_ptr_i = 32'h50;
    wait_rsp();
    chk(!r_fault && r_haddr == {27'h123_4567, ga[20:0]}, "R9 walk uses sampled root",
        64'(r_haddr), 64'({27'h123_4567, ga[20:0]}));
    ack_rsp();
    send_req(6'd5, ga); wait_rsp();
    chk(rd_log.size() > 0 && rd_log[0] == blk(32'h50) + 48'd40, "R9 next walk uses new root",
        rd_log.size() > 0 ? 64'(rd_log[0]) : 64'h0, 64'(blk(32'h50) + 48'd40));
    ack_rsp();
    root_ptr_i = 32'h10;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // tables: reserved bits set everywhere to cover R11
    put64(blk(32'h10) + 48'd40,  64'hFFF0_0000_0000_020F);   // fn 5  -> 0x20
    put64(blk(32'h10) + 48'd504, 64'h8000_0000_0000_020F);   // fn 63 -> 0x20
    put64(blk(32'h10) + 48'd56,  64'h0000_0000_0000_0200);   // fn 7 invalid
    put64(blk(32'h10) + 48'd72,  64'h0000_0000_0000_0401);   // fn 9 -> 0x40
    put64(blk(32'h50) + 48'd40,  64'h0000_0000_0000_0201);   // root 0x50, fn 5
    put64(blk(32'h20) + 48'h0A5 * 8,  64'h0FF0_0000_0000_030F);
    put64(blk(32'h20) + 48'h1FFF * 8, 64'h0000_0000_0000_0301);
    put32(blk(32'h30) + 48'h1235 * 4, {27'h123_4567, 5'b11111});
    put32(blk(32'h30) + 48'h1234 * 4, {27'h0AB_CDEF, 5'b00001});
    put32(blk(32'h30) + 48'h3FFF * 4, {27'h7FF_FFFF, 5'b00001});
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fn_zero();
    t_good(6'd5, ga_of(13'h0A5, 14'h1235, 21'h1_ABCD), 32'h10, 32'h20, 32'h30, 27'h123_4567);
    t_good(6'd5, ga_of(13'h0A5, 14'h1234, 21'h0_0042), 32'h10, 32'h20, 32'h30, 27'h0AB_CDEF);
    t_good(6'd63, ga_of(13'h1FFF, 14'h3FFF, 21'h1F_FFFF), 32'h10, 32'h20, 32'h30, 27'h7FF_FFFF);
    t_fault(6'd7, ga_of(13'h0A5, 14'h1235, 21'h0), 2'd0);
    t_fault(6'd9, ga_of(13'h0A5, 14'h1235, 21'h0), 2'd1);
    t_fault(6'd5, ga_of(13'h0A5, 14'h0007, 21'h0), 2'd2);
    t_backpressure();
    t_root_change();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule